// File: doc/BRIEF.md
# Synchronous Serial Port with Transmit and Receive FIFOs

This block is a four-wire synchronous serial port that works either as the bus master or as a bus slave. Software controls it through three registers on a small select/strobe register bus. A control register holds the enable, the role, a slave output release, the frame length and the master clock divider. A data register queues transmit frames and returns received frames. A status register reports the FIFO levels, activity and receive overrun. Each direction has an 8-entry FIFO. Frames are 4 to 16 bits long, are sent MSB first, and use clock polarity 0 and phase 0: the clock idles low, data is sampled on the rising edge and changed on the falling edge.

A shift engine state machine carries the frames. It has four states:
- `ENG_IDLE`: nothing is being shifted.
- `ENG_LOW` and `ENG_HIGH`: the two halves of each master clock period.
- `ENG_SLV`: the port is a slave and an external master has selected it.

The transitions are as follows:
- **start** (IDLE→LOW): a master that is enabled finds the transmit FIFO not empty. The engine pops a word and pulls the select line low.
- **sample** (LOW→HIGH): a half period has elapsed. MISO is captured.
- **shift** (HIGH→LOW): a half period has elapsed and bits remain. The next bit is presented.
- **chain** (HIGH→LOW): the frame is done and another word is waiting. The engine pops it without releasing select.
- **finish** (HIGH→IDLE): the frame is done and the transmit FIFO is empty. Select is released.
- **select** (IDLE→SLV): the slave sees its select input go low.
- **deselect** (SLV→IDLE): the select input goes high.
- **disable** (any→IDLE): the enable bit is cleared.

Top module: `spi_fifo_port`

## Requirements
- R1: After reset, status reads 0x0003, `ssel_n_o` is 1, `sclk_o` is 0, and both `miso_oe` and `master_oe` are 0.
- R2: The role bit can change only while the enable bit is 0. A control write made while enabled leaves the role as it was, while the other control fields still update.
- R3: `miso_oe` is 1 exactly when the port is enabled, in slave role (role bit 1), has control bit 2 (release) clear, and sees `ssel_n_i` low.
- R4: A data write is taken only while the transmit FIFO holds fewer than 8 words. A write to a full FIFO is discarded and never transmitted.
- R5: The frame has (control bits 7:4)+1 bits, with a minimum of 4. On write only the low bits are used. On read, the bits above the frame are 0.
- R6: A word written to an empty FIFO while the master is idle starts a frame at once. `ssel_n_o` stays low across back-to-back frames until the FIFO is empty and the last frame has ended.
- R7: The master clock idles low and has a period of 2×(control bits 15:8 + 1) system clocks. MOSI carries the frame MSB first.
- R8: A data read returns the oldest received frame and removes it. A read with the receive FIFO empty returns 0 and changes nothing.
- R9: Status bit 0 is set when the transmit FIFO is empty. Bit 1 is set when the transmit FIFO is not full. Bit 2 is set when the receive FIFO is not empty.
- R10: A frame that completes while the receive FIFO holds 8 words is dropped, and status bit 4 is set and stays set.
- R11: Status bit 3 is set while a frame is in progress or the transmit FIFO is not empty.
- R12: In slave role the port samples `mosi_i` on rising `sclk_i` while `ssel_n_i` is low, and shifts out its queued word MSB first on `miso_o`. The master outputs stay idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_sel | input | 2 | Register select: 0 control, 1 data, 2 status |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; a data read pops the receive FIFO |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register |
| sclk_o | output | 1 | Master serial clock |
| ssel_n_o | output | 1 | Master select, active low |
| mosi_o | output | 1 | Master data out |
| master_oe | output | 1 | Drive enable for the three master outputs |
| miso_i | input | 1 | Master data in |
| sclk_i | input | 1 | Slave serial clock in |
| ssel_n_i | input | 1 | Slave select in, active low |
| mosi_i | input | 1 | Slave data in |
| miso_o | output | 1 | Slave data out |
| miso_oe | output | 1 | Drive enable for `miso_o` |

## Verification
The assertions check four properties on every cycle:
- Neither FIFO is pushed when full or popped when empty.
- The role bit never moves while the port is enabled.
- The overrun flag never clears.
- A port in slave role never toggles the master clock or select.

Frame timing, MSB-first bit order, select held across chained frames, right-justification, the exact count of bits sent after a full-FIFO write, and the data a slave returns can be shown only by the bench's scenarios. The bench also compares `miso_oe` against a behavioural model on every clock.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_LOW,
        ENG_HIGH,
        ENG_SLV
    } eng_state_t;

    localparam logic [1:0] SEL_CTL  = 2'd0;
    localparam logic [1:0] SEL_DATA = 2'd1;
    localparam logic [1:0] SEL_STAT = 2'd2;
endpackage

// File: rtl/spi_sync_fifo.sv
module spi_sync_fifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic [AW:0]      cnt;
    logic             do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == (AW+1)'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            cnt <= cnt + {{AW{1'b0}}, do_push} - {{AW{1'b0}}, do_pop};
        end
    end

    // R4: the caller must gate writes on full
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst) push |-> !full);
    // R8: the caller must gate reads on empty
    p_no_underflow_r8: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_fifo_pkg::*;
#(
    parameter int DW = 16,
    parameter int HW = 8,
    localparam int LW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enable,
    input  logic          slave,
    input  logic [LW-1:0] last_idx,
    input  logic [DW-1:0] frame_mask,
    input  logic [HW-1:0] half_m1,
    input  logic          tx_empty,
    input  logic [DW-1:0] tx_data,
    output logic          tx_pop,
    input  logic          rx_full,
    output logic          rx_push,
    output logic [DW-1:0] rx_data,
    output logic          ovr_set,
    input  logic          miso_i,
    input  logic          sclk_i,
    input  logic          ssel_n_i,
    input  logic          mosi_i,
    output logic          sclk_o,
    output logic          ssel_n_o,
    output logic          mosi_o,
    output logic          miso_o,
    output logic          active
);
    eng_state_t    state, nxt;
    logic [DW-1:0] txsh, rxsh, rx_next, ld_val;
    logic [LW-1:0] bitcnt;
    logic [HW-1:0] divcnt;
    logic          reload, tick, load, smp, shf, done, smp_bit;
    logic [2:0]    s_sclk;
    logic [1:0]    s_ssel, s_mosi;
    logic          sclk_rise, sclk_fall, selected;

    assign sclk_rise = s_sclk[1] && !s_sclk[2];
    assign sclk_fall = !s_sclk[1] && s_sclk[2];
    assign selected  = !s_ssel[1];
    assign tick      = (divcnt == half_m1);
    assign smp_bit   = slave ? s_mosi[1] : miso_i;
    assign rx_next   = {rxsh[DW-2:0], smp_bit};
    assign ld_val    = tx_empty ? '0 : tx_data;

    // next-state and strobes
    always_comb begin
        nxt    = state;
        tx_pop = 1'b0;
        load   = 1'b0;
        smp    = 1'b0;
        shf    = 1'b0;
        done   = 1'b0;
        if (!enable) begin
            nxt = ENG_IDLE;
        end else begin
            unique case (state)
                ENG_IDLE: begin
                    if (!slave && !tx_empty) begin
                        nxt = ENG_LOW; tx_pop = 1'b1; load = 1'b1;
                    end else if (slave && selected) begin
                        nxt = ENG_SLV; tx_pop = !tx_empty; load = 1'b1;
                    end
                end
                ENG_LOW: begin
                    if (tick) begin nxt = ENG_HIGH; smp = 1'b1; end
                end
                ENG_HIGH: begin
                    if (tick) begin
                        if (bitcnt == '0) begin
                            done = 1'b1;
                            if (!tx_empty) begin
                                nxt = ENG_LOW; tx_pop = 1'b1; load = 1'b1;
                            end else begin
                                nxt = ENG_IDLE;
                            end
                        end else begin
                            nxt = ENG_LOW; shf = 1'b1;
                        end
                    end
                end
                ENG_SLV: begin
                    if (!selected) begin
                        nxt = ENG_IDLE;
                    end else begin
                        if (sclk_rise) begin
                            smp  = 1'b1;
                            done = (bitcnt == '0);
                        end
                        if (sclk_fall) begin
                            if (reload) begin load = 1'b1; tx_pop = !tx_empty; end
                            else shf = 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    assign rx_push = done && !rx_full;
    assign ovr_set = done && rx_full;
    assign rx_data = (slave ? rx_next : rxsh) & frame_mask;

    always_ff @(posedge clk) begin
        if (rst) state <= ENG_IDLE;
        else     state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_sclk <= '0;
            s_ssel <= '1;
            s_mosi <= '0;
            txsh   <= '0;
            rxsh   <= '0;
            bitcnt <= '0;
            divcnt <= '0;
            reload <= 1'b0;
        end else begin
            s_sclk <= {s_sclk[1:0], sclk_i};
            s_ssel <= {s_ssel[0], ssel_n_i};
            s_mosi <= {s_mosi[0], mosi_i};
            if ((state == ENG_LOW || state == ENG_HIGH) && !tick) divcnt <= divcnt + 1'b1;
            else divcnt <= '0;
            if (load)     txsh <= ld_val;
            else if (shf) txsh <= txsh << 1;
            if (load && state != ENG_SLV) rxsh <= '0;
            else if (smp)                 rxsh <= rx_next;
            if (load && state != ENG_SLV)           bitcnt <= last_idx;
            else if (done)                          bitcnt <= last_idx;
            else if (state == ENG_SLV ? smp : shf)  bitcnt <= bitcnt - 1'b1;
            if (state == ENG_IDLE || load) reload <= 1'b0;
            else if (done && state == ENG_SLV) reload <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        sclk_o   = (state == ENG_HIGH);
        ssel_n_o = !(state == ENG_LOW || state == ENG_HIGH);
        mosi_o   = (state == ENG_LOW || state == ENG_HIGH) ? txsh[last_idx] : 1'b0;
        miso_o   = txsh[last_idx];
        active   = (state != ENG_IDLE);
    end
endmodule

// File: rtl/spi_fifo_port.sv
module spi_fifo_port
    import spi_fifo_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    reg_sel,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          sclk_o,
    output logic          ssel_n_o,
    output logic          mosi_o,
    output logic          master_oe,
    input  logic          miso_i,
    input  logic          sclk_i,
    input  logic          ssel_n_i,
    input  logic          mosi_i,
    output logic          miso_o,
    output logic          miso_oe
);
    localparam int LW = $clog2(DW);
    localparam int HW = DW - 8;
    localparam logic [DW-1:0] ONES = '1;

    logic          ctl_en, ctl_role, ctl_sod, ovr;
    logic [LW-1:0] ctl_len, last_idx;
    logic [HW-1:0] ctl_half;
    logic [DW-1:0] frame_mask, tx_dout, rx_dout, rx_data;
    logic          tx_push, tx_pop, tx_empty, tx_full;
    logic          rx_push, rx_pop, rx_empty, rx_full;
    logic          ovr_set, active, eng_miso;

    assign last_idx   = (ctl_len < LW'(3)) ? LW'(3) : ctl_len;
    assign frame_mask = ONES >> (DW - 1 - int'(last_idx));
    assign tx_push    = reg_wr && reg_sel == SEL_DATA && !tx_full;
    assign rx_pop     = reg_rd && reg_sel == SEL_DATA && !rx_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_en   <= 1'b0;
            ctl_role <= 1'b0;
            ctl_sod  <= 1'b0;
            ctl_len  <= '0;
            ctl_half <= '0;
            ovr      <= 1'b0;
        end else begin
            if (reg_wr && reg_sel == SEL_CTL) begin
                ctl_en   <= reg_wdata[0];
                if (!ctl_en) ctl_role <= reg_wdata[1];
                ctl_sod  <= reg_wdata[2];
                ctl_len  <= reg_wdata[7:4];
                ctl_half <= reg_wdata[DW-1:8];
            end
            if (ovr_set) ovr <= 1'b1;
        end
    end

    always_comb begin
        unique case (reg_sel)
            SEL_CTL:  reg_rdata = {ctl_half, ctl_len, 1'b0, ctl_sod, ctl_role, ctl_en};
            SEL_DATA: reg_rdata = rx_empty ? '0 : rx_dout;
            SEL_STAT: reg_rdata = {{(DW-5){1'b0}}, ovr, active || !tx_empty,
                                   !rx_empty, !tx_full, tx_empty};
            default:  reg_rdata = '0;
        endcase
    end

    spi_sync_fifo #(.WIDTH(DW), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst(rst), .push(tx_push), .din(reg_wdata & frame_mask),
        .pop(tx_pop), .dout(tx_dout), .empty(tx_empty), .full(tx_full)
    );

    spi_sync_fifo #(.WIDTH(DW), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .push(rx_push), .din(rx_data),
        .pop(rx_pop), .dout(rx_dout), .empty(rx_empty), .full(rx_full)
    );

    spi_shift_engine #(.DW(DW), .HW(HW)) u_eng (
        .clk(clk), .rst(rst), .enable(ctl_en), .slave(ctl_role),
        .last_idx(last_idx), .frame_mask(frame_mask), .half_m1(ctl_half),
        .tx_empty(tx_empty), .tx_data(tx_dout), .tx_pop(tx_pop),
        .rx_full(rx_full), .rx_push(rx_push), .rx_data(rx_data), .ovr_set(ovr_set),
        .miso_i(miso_i), .sclk_i(sclk_i), .ssel_n_i(ssel_n_i), .mosi_i(mosi_i),
        .sclk_o(sclk_o), .ssel_n_o(ssel_n_o), .mosi_o(mosi_o), .miso_o(eng_miso),
        .active(active)
    );

    assign master_oe = ctl_en && !ctl_role;
    assign miso_oe   = ctl_en && ctl_role && !ctl_sod && !ssel_n_i;
    assign miso_o    = eng_miso;

    p_role_locked_r2: assert property (@(posedge clk) disable iff (rst)
        $past(ctl_en) |-> $stable(ctl_role));
    p_ovr_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        $past(ovr) |-> ovr);
    p_slave_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        ctl_role |-> (ssel_n_o && !sclk_o));
endmodule

// File: tb/tb_spi_fifo_port.sv
module tb_spi_fifo_port;
    logic        clk = 1'b0, rst = 1'b1;
    logic [1:0]  reg_sel = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [15:0] reg_wdata = '0, reg_rdata;
    logic        sclk_o, ssel_n_o, mosi_o, master_oe, miso_i, miso_o, miso_oe;
    logic        sclk_i = 1'b0, ssel_n_i = 1'b1, mosi_i = 1'b0, lb = 1'b0;

    always #2 clk = ~clk;
    assign miso_i = lb ? mosi_o : 1'b0;

    spi_fifo_port dut (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk_o(sclk_o),
        .ssel_n_o(ssel_n_o), .mosi_o(mosi_o), .master_oe(master_oe), .miso_i(miso_i),
        .sclk_i(sclk_i), .ssel_n_i(ssel_n_i), .mosi_i(mosi_i), .miso_o(miso_o),
        .miso_oe(miso_oe)
    );

    int n_cmp = 0, n_bad = 0;
    bit m_en = 0, m_role = 0, m_sod = 0;
    int rise_cnt = 0, ssel_rise = 0, cyc = 0, last_rise = 0, period = 0;
    logic [15:0] cap = '0;
    logic sclk_q = 1'b0, ssel_q = 1'b1;

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // per-clock model comparison and line monitors
    always @(negedge clk) begin
        #1;
        cyc++;
        if (!rst) chk("R3 miso drive", int'(miso_oe), int'(m_en && m_role && !m_sod && !ssel_n_i));
        if (sclk_o && !sclk_q) begin
            rise_cnt++;
            cap = {cap[14:0], mosi_o};
            if (last_rise != 0) period = cyc - last_rise;
            last_rise = cyc;
        end
        if (ssel_n_o && !ssel_q) ssel_rise++;
        sclk_q = sclk_o;
        ssel_q = ssel_n_o;
    end

    task automatic wr(input logic [1:0] s, input logic [15:0] d);
        @(negedge clk);
        reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        if (s == 2'd0) begin
            if (!m_en) m_role = d[1];
            m_en = d[0];
            m_sod = d[2];
        end
    endtask

    task automatic rd(input logic [1:0] s, output logic [15:0] v);
        @(negedge clk);
        reg_sel = s; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [15:0] v;
        for (int i = 0; i < 60000; i++) begin
            rd(2'd2, v);
            if (!v[3]) break;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        logic [15:0] v;
        logic [7:0]  scap;
        logic [7:0]  sv;
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(2'd2, v);
        chk("R1 status", v, 16'h0003);
        chk("R1 ssel_n_o", int'(ssel_n_o), 1);
        chk("R1 sclk_o", int'(sclk_o), 0);
        chk("R1 oe", int'({master_oe, miso_oe}), 0);

        // R7 master single frame with loopback, divisor 4
        lb = 1'b1;
        wr(2'd0, 16'h0171);
        rise_cnt = 0; last_rise = 0;
        wr(2'd1, 16'h00A5);
        rd(2'd2, v);
        chk("R11 busy during frame", int'(v[3]), 1);
        wait_idle();
        chk("R7 rising edges", rise_cnt, 8);
        chk("R7 MSB-first mosi", int'(cap[7:0]), 8'hA5);
        chk("R7 clock period", period, 4);
        rd(2'd2, v);
        chk("R9 status after frame", v, 16'h0007);
        rd(2'd1, v);
        chk("R8 loopback word", v, 16'h00A5);
        rd(2'd2, v);
        chk("R9 status after read", v, 16'h0003);

        // R5 short frame right-justified
        wr(2'd0, 16'h0131);
        wr(2'd1, 16'hFFF6);
        wait_idle();
        rd(2'd1, v);
        chk("R5 four-bit frame", v, 16'h0006);

        // R6 chained frames keep select low
        wr(2'd0, 16'h0171);
        ssel_rise = 0;
        wr(2'd1, 16'h0011);
        wr(2'd1, 16'h0022);
        wr(2'd1, 16'h0033);
        wait_idle();
        chk("R6 select releases once", ssel_rise, 1);
        rd(2'd1, v); chk("R8 order 1", v, 16'h0011);
        rd(2'd1, v); chk("R8 order 2", v, 16'h0022);
        rd(2'd1, v); chk("R8 order 3", v, 16'h0033);
        rd(2'd1, v); chk("R8 empty read", v, 16'h0000);
        rd(2'd2, v); chk("R8 status unchanged", v, 16'h0003);

        // R4 / R10 full transmit FIFO and receive overrun
        wr(2'd0, 16'h7F71);
        rise_cnt = 0;
        for (int i = 0; i < 9; i++) wr(2'd1, 16'h0040 + 16'(i));
        rd(2'd2, v);
        chk("R9 tx full status", v, 16'h0008);
        wr(2'd1, 16'h00EE);
        wait_idle();
        chk("R4 dropped write not sent", rise_cnt, 72);
        rd(2'd2, v);
        chk("R10 overrun status", v, 16'h0017);
        for (int i = 0; i < 8; i++) begin
            rd(2'd1, v);
            chk("R10 kept frames", v, 16'h0040 + 16'(i));
        end
        rd(2'd2, v);
        chk("R10 sticky overrun", v, 16'h0013);

        // R12 slave frame
        lb = 1'b0;
        wr(2'd0, 16'h0000);
        wr(2'd0, 16'h0073);
        wr(2'd1, 16'h003C);
        sv = 8'hC3; scap = '0;
        ssel_n_i = 1'b0;
        repeat (8) @(negedge clk);
        for (int b = 7; b >= 0; b--) begin
            mosi_i = sv[b];
            repeat (4) @(negedge clk);
            scap = {scap[6:0], miso_o};
            sclk_i = 1'b1;
            repeat (8) @(negedge clk);
            sclk_i = 1'b0;
            repeat (4) @(negedge clk);
        end
        repeat (8) @(negedge clk);
        ssel_n_i = 1'b1;
        repeat (4) @(negedge clk);
        chk("R12 slave miso bits", int'(scap), 8'h3C);
        rd(2'd1, v);
        chk("R12 slave received", v, 16'h00C3);
        chk("R12 master select idle", int'(ssel_n_o), 1);

        // R3 release, R2 role lock
        wr(2'd0, 16'h0077);
        ssel_n_i = 1'b0;
        repeat (4) @(negedge clk);
        chk("R3 released miso", int'(miso_oe), 0);
        ssel_n_i = 1'b1;
        wr(2'd0, 16'h0075);
        rd(2'd0, v);
        chk("R2 role kept while enabled", v, 16'h0077);
        wr(2'd0, 16'h0004);
        rd(2'd0, v);
        chk("R2 role kept on disabling write", v, 16'h0006);
        wr(2'd0, 16'h0000);
        rd(2'd0, v);
        chk("R2 role changes when disabled", v, 16'h0000);

        repeat (4) @(negedge clk);
        report();
    end
endmodule